// File: doc/BRIEF.md
# GPIO Port Register File

This block holds the configuration of one general-purpose I/O port of up to 32 pins. Software reaches it through a simple register interface with one cycle per access. The interface has an address, a write enable, write data and read data. Every configuration register has three addresses. The base address reads the register. The address at base+4 ORs the written word into the register. The address at base+8 clears every bit that is 1 in the written word. Single bits can therefore be changed without a read-modify-write sequence, and two agents that own different pins never disturb each other.

From the stored bits the block works out the role of each pin. Three bits set the role: a routing bit, a select bit and a trigger bit. Together they choose plain GPIO, interrupt input, or one of three alternate peripheral functions. A GPIO pin drives its data bit when its direction bit is 1. An interrupt pin reports its edge/level choice and its polarity to the interrupt logic outside the block. Pad drivers, peripherals and the interrupt logic are outside the block; they connect only through ports. The live pin levels can be read back at offset 0x00.

Top module: `gpio_port_regs`

## Requirements
- R1: Reset is asserted low and acts asynchronously. While reset is held and after it is released, every register holds 0, except the interrupt mask, which holds 1 in every implemented bit. Every pin therefore starts as a GPIO input with its pull-up on and its interrupt masked.
- R2: A read at offset 0x00 returns the live `pin_in` levels, with unimplemented pins forced to 0. A write to offset 0x00 changes nothing.
- R3: A write to a set address (register base + 0x4) ORs the write data into that register. Bits written as 0 keep their value.
- R4: A write to a clear address (register base + 0x8) clears every bit that is 1 in the write data. Bits written as 0 keep their value.
- R5: Each register has a base address, and a read at the base returns the register. The bases are: output data 0x10, interrupt mask 0x20, pull disable 0x30, routing 0x40, select 0x50, direction 0x60, trigger 0x70. A write to a base address is ignored.
- R6: A pin is in GPIO mode when its routing bit is 0 and its select bit is 0. In GPIO mode, `pad_oe` equals the direction bit (1 = output) and `pad_out` equals the data bit. In every other mode both are 0.
- R7: A pin is in interrupt mode when its routing bit is 0 and its select bit is 1. In interrupt mode, `int_en` is 1, `int_edge` equals the trigger bit (1 = edge, 0 = level), and `int_rising` equals the direction bit (1 = rising edge or high level). In every other mode these three outputs are 0.
- R8: A routing bit of 1 selects an alternate function, and exactly one of three outputs is high. Select 0 raises `alt_fn1`. Select 1 with trigger 0 raises `alt_fn2`. Select 1 with trigger 1 raises `alt_fn3`.
- R9: `pull_up_en` of a pin is the inverse of its pull-disable bit.
- R10: Pins at index NUM_PINS and above are not implemented. They read back as 0 in every register, writes to them have no effect, and every output bit for them is 0.
- R11: The port decodes only the eight base addresses and the set and clear addresses of groups 0x10 to 0x70. A read from any other address returns 0, including set or clear addresses, unaligned addresses and addresses at or above 0x80. A write to any other address is ignored.
- R12: `int_mask` presents the interrupt mask register (1 = masked).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released in step with the clock |
| bus_addr | input | ADDR_W | Byte address inside the port window |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, in the same cycle |
| pin_in | input | 32 | Live input levels from the pads |
| pad_oe | output | 32 | Output enable for each pin (GPIO mode) |
| pad_out | output | 32 | Output level for each pin (GPIO mode) |
| pull_up_en | output | 32 | Pull-up enable for each pin |
| int_en | output | 32 | Pin is in interrupt mode |
| int_edge | output | 32 | Interrupt is edge-sensitive (1) or level-sensitive (0) |
| int_rising | output | 32 | Interrupt polarity: rising edge or high level (1) |
| int_mask | output | 32 | Interrupt mask for each pin |
| alt_fn1 | output | 32 | Alternate function 1 routed |
| alt_fn2 | output | 32 | Alternate function 2 routed |
| alt_fn3 | output | 32 | Alternate function 3 routed |

## Verification
The bench builds the port with NUM_PINS set to 31 and keeps the default 8-bit address. With one pin missing, the top bit becomes an unimplemented pin. Writes of all ones, reads of live pins with bit 31 high, and the decoded outputs all have to keep that bit at 0. With the default 32 pins that case could not be reached. The full 8-bit window also lets stimulus reach unaligned offsets, the alias addresses of the read-only pin group, and the unmapped range above 0x80.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int PORT_W     = 32;
  localparam int NUM_GROUPS = 8;
  localparam int GRP_IDX_W  = $clog2(NUM_GROUPS);

  // group index = address bits [6:4]
  localparam int GRP_PIN  = 0;
  localparam int GRP_DATA = 1;
  localparam int GRP_MASK = 2;
  localparam int GRP_PULL = 3;
  localparam int GRP_FUNC = 4;
  localparam int GRP_SEL  = 5;
  localparam int GRP_DIR  = 6;
  localparam int GRP_TRIG = 7;

  // low nibble of the address selects the access kind
  localparam logic [3:0] SUB_READ = 4'h0;
  localparam logic [3:0] SUB_SET  = 4'h4;
  localparam logic [3:0] SUB_CLR  = 4'h8;

  typedef enum logic [2:0] {
    MODE_GPIO,
    MODE_IRQ,
    MODE_ALT1,
    MODE_ALT2,
    MODE_ALT3
  } pin_mode_e;

  function automatic logic [PORT_W-1:0] impl_mask(input int n);
    logic [PORT_W-1:0] m;
    m = '0;
    for (int i = 0; i < PORT_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  we,
  output logic [NUM_GROUPS-1:0] set_stb,
  output logic [NUM_GROUPS-1:0] clr_stb,
  output logic                  rd_hit,
  output logic [GRP_IDX_W-1:0]  rd_idx
);

  logic                 in_win;
  logic [GRP_IDX_W-1:0] grp;
  logic [3:0]           sub;

  always_comb begin
    in_win  = (addr >> 7) == '0;
    grp     = addr[6:4];
    sub     = addr[3:0];
    rd_hit  = in_win && (sub == SUB_READ);
    rd_idx  = grp;
    set_stb = '0;
    clr_stb = '0;
    if (we && in_win && (grp != GRP_IDX_W'(GRP_PIN))) begin
      if (sub == SUB_SET) set_stb[grp] = 1'b1;
      if (sub == SUB_CLR) clr_stb[grp] = 1'b1;
    end
  end

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int           W       = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] KEEP    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd_en;

  always_comb begin
    upd_en = set_stb | clr_stb;
    q_nxt  = q_r;
    if (set_stb)      q_nxt = q_r | wdata;
    else if (clr_stb) q_nxt = q_r & ~wdata;
    q_nxt = q_nxt & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= RST_VAL & KEEP;
    else if (upd_en) q_r <= q_nxt;
  end

  assign q = q_r;

  // R3: bits written as 1 through the set alias are 1 afterwards, the rest keep
  a_r3_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(wdata & KEEP)) == $past(wdata & KEEP)) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  // R4: bits written as 1 through the clear alias are 0 afterwards, the rest keep
  a_r4_clr_ands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(wdata)) == '0) &&
                ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

  // R10: unimplemented bits never become 1
  a_r10_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~KEEP) == '0);

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] pull_q,
  input  logic [PORT_W-1:0] func_q,
  input  logic [PORT_W-1:0] sel_q,
  input  logic [PORT_W-1:0] dir_q,
  input  logic [PORT_W-1:0] trig_q,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pull_up_en,
  output logic [PORT_W-1:0] int_en,
  output logic [PORT_W-1:0] int_edge,
  output logic [PORT_W-1:0] int_rising,
  output logic [PORT_W-1:0] alt_fn1,
  output logic [PORT_W-1:0] alt_fn2,
  output logic [PORT_W-1:0] alt_fn3
);

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i < NUM_PINS) begin : g_impl
      pin_mode_e mode;
      logic      is_gpio;
      logic      is_irq;

      always_comb begin
        if (!func_q[i])     mode = sel_q[i] ? MODE_IRQ : MODE_GPIO;
        else if (!sel_q[i]) mode = MODE_ALT1;
        else                mode = trig_q[i] ? MODE_ALT3 : MODE_ALT2;
      end

      assign is_gpio       = (mode == MODE_GPIO);
      assign is_irq        = (mode == MODE_IRQ);
      assign pad_oe[i]     = is_gpio & dir_q[i];
      assign pad_out[i]    = is_gpio & data_q[i];
      assign int_en[i]     = is_irq;
      assign int_edge[i]   = is_irq & trig_q[i];
      assign int_rising[i] = is_irq & dir_q[i];
      assign alt_fn1[i]    = (mode == MODE_ALT1);
      assign alt_fn2[i]    = (mode == MODE_ALT2);
      assign alt_fn3[i]    = (mode == MODE_ALT3);
      assign pull_up_en[i] = ~pull_q[i];
    end else begin : g_absent
      assign pad_oe[i]     = 1'b0;
      assign pad_out[i]    = 1'b0;
      assign int_en[i]     = 1'b0;
      assign int_edge[i]   = 1'b0;
      assign int_rising[i] = 1'b0;
      assign alt_fn1[i]    = 1'b0;
      assign alt_fn2[i]    = 1'b0;
      assign alt_fn3[i]    = 1'b0;
      assign pull_up_en[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_out,
  output logic [31:0]       pull_up_en,
  output logic [31:0]       int_en,
  output logic [31:0]       int_edge,
  output logic [31:0]       int_rising,
  output logic [31:0]       int_mask,
  output logic [31:0]       alt_fn1,
  output logic [31:0]       alt_fn2,
  output logic [31:0]       alt_fn3
);

  localparam logic [PORT_W-1:0] KEEP = impl_mask(NUM_PINS);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NUM_GROUPS-1:0]        set_stb;
  logic [NUM_GROUPS-1:0]        clr_stb;
  logic                         rd_hit;
  logic [GRP_IDX_W-1:0]         rd_idx;
  logic [PORT_W-1:0]            reg_q [NUM_GROUPS];
  logic [NUM_GROUPS*PORT_W-1:0] reg_flat;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .we      (bus_we),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .rd_hit  (rd_hit),
    .rd_idx  (rd_idx)
  );

  assign reg_q[GRP_PIN] = '0;

  for (genvar g = 1; g < NUM_GROUPS; g++) begin : g_grp
    gpio_setclr_reg #(
      .W       (PORT_W),
      .RST_VAL ((g == GRP_MASK) ? KEEP : '0),
      .KEEP    (KEEP)
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .set_stb (set_stb[g]),
      .clr_stb (clr_stb[g]),
      .wdata   (bus_wdata),
      .q       (reg_q[g])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flat
    assign reg_flat[g*PORT_W +: PORT_W] = reg_q[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      if (rd_idx == GRP_IDX_W'(GRP_PIN)) bus_rdata = pin_in & KEEP;
      else                               bus_rdata = reg_q[rd_idx];
    end
  end

  assign int_mask = reg_q[GRP_MASK];

  gpio_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .data_q     (reg_q[GRP_DATA]),
    .pull_q     (reg_q[GRP_PULL]),
    .func_q     (reg_q[GRP_FUNC]),
    .sel_q      (reg_q[GRP_SEL]),
    .dir_q      (reg_q[GRP_DIR]),
    .trig_q     (reg_q[GRP_TRIG]),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pull_up_en (pull_up_en),
    .int_en     (int_en),
    .int_edge   (int_edge),
    .int_rising (int_rising),
    .alt_fn1    (alt_fn1),
    .alt_fn2    (alt_fn2),
    .alt_fn3    (alt_fn3)
  );

  // R2: offset 0x00 shows the live pins, limited to implemented ones
  a_r2_pin_live: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr == '0) |-> (bus_rdata == (pin_in & KEEP)));

  // R11: alias, unaligned and out-of-window reads give 0
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((bus_addr[3:0] != 4'h0) || ((bus_addr >> 7) != '0)) |-> (bus_rdata == '0));

  // R5: writes to a read address leave every register unchanged
  a_r5_base_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && (bus_addr[3:0] == 4'h0)) |=> $stable(reg_flat));

  // R6: a pin can only drive while no other role claims it
  a_r6_oe_gpio_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pad_oe & (int_en | alt_fn1 | alt_fn2 | alt_fn3)) == '0);

  // R8: at most one role per pin
  for (genvar i = 0; i < PORT_W; i++) begin : g_chk
    a_r8_one_role: assert property (@(posedge clk) disable iff (!rst_int_n)
      $onehot0({int_en[i], alt_fn1[i], alt_fn2[i], alt_fn3[i]}));
  end

endmodule

// File: tb/test_gpio_port_regs.sv
`timescale 1ns/1ps
module test_gpio_port_regs;

  localparam int          NUM_PINS = 31;
  localparam logic [31:0] IMPL = (NUM_PINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NUM_PINS) - 32'd1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata, bus_rdata, pin_in;
  logic [31:0] pad_oe, pad_out, pull_up_en, int_en, int_edge, int_rising;
  logic [31:0] int_mask, alt_fn1, alt_fn2, alt_fn3;

  int checks = 0;
  int errors = 0;

  // model registers, indexed by address bits [6:4]
  logic [31:0] m [8];

  always #5 clk = ~clk;

  gpio_port_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(8)) i_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pull_up_en(pull_up_en),
    .int_en(int_en), .int_edge(int_edge), .int_rising(int_rising),
    .int_mask(int_mask), .alt_fn1(alt_fn1), .alt_fn2(alt_fn2), .alt_fn3(alt_fn3)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m[k]) m[k] = 32'h0;
    m[2] = IMPL;
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] p);
    if (a >= 8'h80 || a[3:0] != 4'h0) return 32'h0;
    if (a == 8'h00) return p & IMPL;
    return m[a[6:4]];
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a < 8'h80 && a[6:4] != 3'd0) begin
      if (a[3:0] == 4'h4) m[a[6:4]] = m[a[6:4]] | (d & IMPL);
      else if (a[3:0] == 4'h8) m[a[6:4]] = m[a[6:4]] & ~d;
    end
  endtask

  task automatic compare_all(input string rd_tag);
    logic [31:0] e_oe, e_out, e_pu, e_ie, e_ied, e_irs, e_a1, e_a2, e_a3;
    {e_oe, e_out, e_pu, e_ie, e_ied, e_irs, e_a1, e_a2, e_a3} = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      e_pu[p] = ~m[3][p];
      if (m[4][p] == 1'b0) begin
        if (m[5][p] == 1'b0) begin
          e_oe[p]  = m[6][p];
          e_out[p] = m[1][p];
        end else begin
          e_ie[p]  = 1'b1;
          e_ied[p] = m[7][p];
          e_irs[p] = m[6][p];
        end
      end else if (m[5][p] == 1'b0) e_a1[p] = 1'b1;
      else if (m[7][p] == 1'b0)     e_a2[p] = 1'b1;
      else                          e_a3[p] = 1'b1;
    end
    chk(rd_tag, $sformatf("rdata @%02h", bus_addr), bus_rdata, exp_read(bus_addr, pin_in));
    chk("R6", "pad_oe", pad_oe, e_oe);
    chk("R6", "pad_out", pad_out, e_out);
    chk("R9", "pull_up_en", pull_up_en, e_pu);
    chk("R7", "int_en", int_en, e_ie);
    chk("R7", "int_edge", int_edge, e_ied);
    chk("R7", "int_rising", int_rising, e_irs);
    chk("R12", "int_mask", int_mask, m[2]);
    chk("R8", "alt_fn1", alt_fn1, e_a1);
    chk("R8", "alt_fn2", alt_fn2, e_a2);
    chk("R8", "alt_fn3", alt_fn3, e_a3);
  endtask

  // one bus cycle: drive at the falling edge, compare, then let the rising edge act
  task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d,
                      input logic [31:0] p, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d; pin_in = p;
    #1;
    compare_all(tag);
    @(posedge clk);
    if (w) model_write(a, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(a, 1'b1, d, 32'h0, "R11");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(a, 1'b0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h0; bus_we = 1'b0; bus_wdata = 32'h0; pin_in = 32'h0;
    model_reset();
    repeat (3) @(posedge clk);
    // R1: reset values while reset is held
    @(negedge clk); #1; compare_all("R1");
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset values after release
    for (int g = 1; g < 8; g++) rd(8'(g << 4), "R1");

    // R2: live pin levels, top pin unimplemented (R10)
    step(8'h00, 1'b0, 32'h0, 32'h1234_5678, "R2");
    step(8'h00, 1'b0, 32'h0, 32'hFFFF_FFFF, "R2");
    step(8'h00, 1'b1, 32'hFFFF_FFFF, 32'h8000_0001, "R2");
    rd(8'h10, "R2");

    // R3: set alias ORs
    wr(8'h14, 32'hA5A5_A5A5); rd(8'h10, "R3");
    wr(8'h14, 32'h0F00_000F); rd(8'h10, "R3");
    // R4: clear alias
    wr(8'h18, 32'h0000_00FF); rd(8'h10, "R4");
    wr(8'h18, 32'h0); rd(8'h10, "R4");
    // R5: base write ignored
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, "R5");
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, "R5");

    // R6: GPIO outputs
    wr(8'h64, 32'h0000_FFFF); rd(8'h60, "R6");
    // R7: interrupt mode on pins 16..23
    wr(8'h54, 32'h00FF_0000); wr(8'h74, 32'h000F_0000); wr(8'h64, 32'h0033_0000);
    rd(8'h50, "R7"); rd(8'h70, "R7");
    // R8: alternate routing on pins 24..31
    wr(8'h44, 32'hFF00_0000); wr(8'h54, 32'h0F00_0000); wr(8'h74, 32'h0300_0000);
    rd(8'h40, "R8");
    wr(8'h58, 32'h0100_0000); rd(8'h50, "R8");
    // R9: pull disables
    wr(8'h34, 32'hF0F0_F0F0); rd(8'h30, "R9");
    wr(8'h38, 32'h3000_0000); rd(8'h30, "R9");
    // R12: unmask lower half
    wr(8'h28, 32'h0000_FFFF); rd(8'h20, "R12");
    wr(8'h24, 32'h0000_0F00); rd(8'h20, "R12");
    // R10: writes to the missing pin have no effect
    wr(8'h74, 32'h8000_0000); rd(8'h70, "R10");
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h20, "R10");

    // R11: unmapped reads and writes
    rd(8'h14, "R11"); rd(8'h28, "R11"); rd(8'h11, "R11"); rd(8'h80, "R11");
    rd(8'h90, "R11"); rd(8'hFC, "R11"); rd(8'h0C, "R11");
    wr(8'h84, 32'hFFFF_FFFF); wr(8'h15, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); wr(8'hC8, 32'hFFFF_FFFF);
    for (int g = 1; g < 8; g++) rd(8'(g << 4), "R11");

    // mixed traffic, compared against the model each cycle
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int         s;
      s = $urandom_range(0, 9);
      a = 8'($urandom_range(0, 8) << 4);
      if (s < 3)      a = a | 8'h04;
      else if (s < 6) a = a | 8'h08;
      else if (s == 6) a = 8'($urandom_range(0, 255));
      step(a, ($urandom_range(0, 2) != 0), $urandom, $urandom, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule